// File: doc/BRIEF.md
# Instruction Fetch and Decode Controller

This block is the front end of a small accumulator-style processor. A single shared word bus connects a word memory and a set of registers: address, program counter, data, accumulator, instruction and temporary. A step counter produces one-hot timing signals, and those signals drive every register transfer. Each instruction takes four cycles. The first cycle copies the program counter into the address register. The second reads the addressed word into the instruction register and advances the program counter. The third splits the instruction into an opcode, an indirect flag and an address field. The fourth reports the instruction's class and returns the step counter to its first state, so the next fetch can begin.

The block does not execute instructions. A downstream execute stage consumes the class indication, the one-hot opcode, the indirect flag and the address register. A halt input freezes the sequence so that nothing moves. A memory write port lets a loader place program words into the memory, and it works at any time.

Top module: `fetch_decode_core`

## Requirements
- R1: While reset is high, the program counter loads `start_addr`, the timing output is T0 (`t_step` = 1) and `instr_class` is zero.
- R2: `t_step` always has exactly one bit set. When not halted it moves T0→T1→T2→T3 on successive clocks, and after T3 it returns to T0.
- R3: During T0 the bus select is 3'b010 (program counter) and the bus carries the program counter zero-extended. At the end of T0 the address register takes that value.
- R4: During T1 the bus select is 3'b111 (memory read) and the bus carries the memory word at the address register. At the end of T1 the instruction register takes that word and the program counter increments modulo 2^ADDR_W.
- R5: During T2 the bus select is 3'b101 (instruction register). At the end of T2 the address register takes IR[11:0] and the indirect flag takes IR[15]. `op_dec` becomes one-hot with bit IR[14:12] set.
- R6: During T3 `instr_class` is one-hot. Bit 0 is memory-direct (opcode ≠ 7, flag 0), bit 1 is memory-indirect (opcode ≠ 7, flag 1), bit 2 is register (opcode 7, flag 0) and bit 3 is I/O (opcode 7, flag 1). Outside T3 it is zero.
- R7: During T3 no transfer takes place: the bus select is 3'b000 and the bus reads zero.
- R8: While `halt` is high, the timing step, program counter, address register and instruction register keep their values.
- R9: When `mem_we` is high, the memory stores `mem_wdata` at `mem_waddr` on the clock edge, whether or not the block is halted. A word written at the end of T0 to the address being fetched is the word seen in T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes sequencing and all register loads |
| start_addr | input | ADDR_W | Program counter value taken during reset |
| mem_we | input | 1 | Memory write enable |
| mem_waddr | input | ADDR_W | Memory write address |
| mem_wdata | input | DATA_W | Memory write data |
| t_step | output | 2**SC_W | One-hot timing signals T0 upward |
| bus_sel | output | 3 | Current bus source code |
| bus_data | output | DATA_W | Value on the shared bus |
| pc | output | ADDR_W | Program counter |
| ar | output | ADDR_W | Address register |
| ir | output | DATA_W | Instruction register |
| i_flag | output | 1 | Indirect flag captured at T2 |
| op_dec | output | 2**(DATA_W-1-ADDR_W) | One-hot decoded opcode |
| instr_class | output | 4 | One-hot instruction class during T3 |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 16-bit word, a 4-bit step counter and the binary-counter timing variant. With the full 4096-word memory, the start address can be placed at 4094. The fetch stream then crosses the top of memory, and the program counter wrap is observed. The program stream covers all four instruction classes and opcodes 0, 1, 6 and 7. It also holds a halt in the middle of a fetch and writes a word to the fetched address one edge before it is read.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

   typedef enum logic [2:0] {
      SRC_NONE = 3'b000,
      SRC_AR   = 3'b001,
      SRC_PC   = 3'b010,
      SRC_DR   = 3'b011,
      SRC_AC   = 3'b100,
      SRC_IR   = 3'b101,
      SRC_TR   = 3'b110,
      SRC_MEM  = 3'b111
   } bus_src_e;

   localparam int CLS_W       = 4;
   localparam int CLS_MEM_DIR = 0;
   localparam int CLS_MEM_IND = 1;
   localparam int CLS_REG     = 2;
   localparam int CLS_IO      = 3;

endpackage

// File: rtl/fdc_seq_timer.sv
module fdc_seq_timer #(
   parameter int SC_W        = 4,
   parameter bit ONEHOT_RING = 1'b0,
   localparam int STEPS      = 2 ** SC_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             advance,
   input  logic             clear,
   output logic [STEPS-1:0] t_step
);

   if (SC_W < 2) begin : g_bad_width
      $error("fdc_seq_timer: SC_W must be at least 2");
   end

   if (ONEHOT_RING) begin : g_ring
      // one flop per step, rotated
      logic [STEPS-1:0] ring_q;
      always_ff @(posedge clk) begin
         if (rst || (advance && clear)) begin
            ring_q <= {{(STEPS-1){1'b0}}, 1'b1};
         end else if (advance) begin
            ring_q <= {ring_q[STEPS-2:0], ring_q[STEPS-1]};
         end
      end
      assign t_step = ring_q;
   end else begin : g_count
      // binary counter feeding a full decoder
      logic [SC_W-1:0] sc_q;
      always_ff @(posedge clk) begin
         if (rst || (advance && clear)) begin
            sc_q <= '0;
         end else if (advance) begin
            sc_q <= sc_q + 1'b1;
         end
      end
      for (genvar k = 0; k < STEPS; k++) begin : g_dec
         assign t_step[k] = (sc_q == SC_W'(k));
      end
   end

endmodule

// File: rtl/fdc_word_mem.sv
module fdc_word_mem #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16,
   localparam int WORDS = 2 ** ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (we) begin
         store[waddr] <= wdata;
      end
   end

   // combinational read inside the cycle
   assign rdata = store[raddr];

endmodule

// File: rtl/fdc_bus_mux.sv
module fdc_bus_mux
   import fdc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  bus_src_e          sel,
   input  logic [ADDR_W-1:0] ar_q,
   input  logic [ADDR_W-1:0] pc_q,
   input  logic [DATA_W-1:0] dr_q,
   input  logic [DATA_W-1:0] ac_q,
   input  logic [DATA_W-1:0] ir_q,
   input  logic [DATA_W-1:0] tr_q,
   input  logic [DATA_W-1:0] mem_q,
   output logic [DATA_W-1:0] bus_q
);

   localparam int PAD_W = DATA_W - ADDR_W;

   always_comb begin
      unique case (sel)
         SRC_AR:   bus_q = {{PAD_W{1'b0}}, ar_q};
         SRC_PC:   bus_q = {{PAD_W{1'b0}}, pc_q};
         SRC_DR:   bus_q = dr_q;
         SRC_AC:   bus_q = ac_q;
         SRC_IR:   bus_q = ir_q;
         SRC_TR:   bus_q = tr_q;
         SRC_MEM:  bus_q = mem_q;
         default:  bus_q = '0;
      endcase
   end

endmodule

// File: rtl/fdc_ctrl.sv
module fdc_ctrl
   import fdc_pkg::*;
#(
   parameter int STEPS = 16
) (
   input  logic             halt,
   input  logic [STEPS-1:0] t_step,
   input  logic             last_opcode,
   input  logic             i_flag,
   output bus_src_e         sel,
   output logic             ld_ar,
   output logic             ld_ir,
   output logic             inc_pc,
   output logic             ld_dec,
   output logic             advance,
   output logic             sc_clear,
   output logic [CLS_W-1:0] cls
);

   logic go;
   assign go      = ~halt;
   assign advance = go;

   always_comb begin
      if (t_step[0]) begin
         sel = SRC_PC;
      end else if (t_step[1]) begin
         sel = SRC_MEM;
      end else if (t_step[2]) begin
         sel = SRC_IR;
      end else begin
         sel = SRC_NONE;
      end
   end

   // address register is loaded from the bus in T0 (PC) and T2 (IR)
   assign ld_ar    = go & (t_step[0] | t_step[2]);
   assign ld_ir    = go & t_step[1];
   assign inc_pc   = go & t_step[1];
   assign ld_dec   = go & t_step[2];
   assign sc_clear = t_step[3];

   always_comb begin
      cls = '0;
      if (t_step[3]) begin
         if (!last_opcode) begin
            cls[i_flag ? CLS_MEM_IND : CLS_MEM_DIR] = 1'b1;
         end else begin
            cls[i_flag ? CLS_IO : CLS_REG] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/fetch_decode_core.sv
module fetch_decode_core
   import fdc_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 16,
   parameter int SC_W        = 4,
   parameter bit ONEHOT_RING = 1'b0,
   localparam int STEPS      = 2 ** SC_W,
   localparam int OPC_W      = DATA_W - 1 - ADDR_W,
   localparam int OPS        = 2 ** OPC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              halt,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_waddr,
   input  logic [DATA_W-1:0] mem_wdata,
   output logic [STEPS-1:0]  t_step,
   output logic [2:0]        bus_sel,
   output logic [DATA_W-1:0] bus_data,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] ar,
   output logic [DATA_W-1:0] ir,
   output logic              i_flag,
   output logic [OPS-1:0]    op_dec,
   output logic [CLS_W-1:0]  instr_class
);

   if (OPC_W < 1) begin : g_bad_split
      $error("fetch_decode_core: DATA_W must exceed ADDR_W + 1");
   end
   if (STEPS < 4) begin : g_bad_steps
      $error("fetch_decode_core: at least four timing steps are needed");
   end

   bus_src_e          sel;
   logic              ld_ar, ld_ir, inc_pc, ld_dec, advance, sc_clear;
   logic [DATA_W-1:0] mem_rd;
   logic [DATA_W-1:0] bus_w;
   logic [DATA_W-1:0] dr_q, ac_q, tr_q;
   logic [OPS-1:0]    dec_w;

   fdc_seq_timer #(.SC_W(SC_W), .ONEHOT_RING(ONEHOT_RING)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .advance (advance),
      .clear   (sc_clear),
      .t_step  (t_step)
   );

   fdc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (ar),
      .rdata (mem_rd)
   );

   fdc_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .sel   (sel),
      .ar_q  (ar),
      .pc_q  (pc),
      .dr_q  (dr_q),
      .ac_q  (ac_q),
      .ir_q  (ir),
      .tr_q  (tr_q),
      .mem_q (mem_rd),
      .bus_q (bus_w)
   );

   fdc_ctrl #(.STEPS(STEPS)) u_ctrl (
      .halt        (halt),
      .t_step      (t_step),
      .last_opcode (op_dec[OPS-1]),
      .i_flag      (i_flag),
      .sel         (sel),
      .ld_ar       (ld_ar),
      .ld_ir       (ld_ir),
      .inc_pc      (inc_pc),
      .ld_dec      (ld_dec),
      .advance     (advance),
      .sc_clear    (sc_clear),
      .cls         (instr_class)
   );

   // opcode field decoder
   for (genvar k = 0; k < OPS; k++) begin : g_opdec
      assign dec_w[k] = (ir[DATA_W-2 -: OPC_W] == OPC_W'(k));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= start_addr;
      end else if (inc_pc) begin
         pc <= pc + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ar <= '0;
      end else if (ld_ar) begin
         ar <= bus_w[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ir <= '0;
      end else if (ld_ir) begin
         ir <= bus_w;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         i_flag <= 1'b0;
         op_dec <= '0;
      end else if (ld_dec) begin
         i_flag <= ir[DATA_W-1];
         op_dec <= dec_w;
      end
   end

   // execute-side registers: bus sources only, held clear in this stage
   always_ff @(posedge clk) begin
      if (rst) begin
         dr_q <= '0;
         ac_q <= '0;
         tr_q <= '0;
      end
   end

   assign bus_sel  = sel;
   assign bus_data = bus_w;

endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16,
   parameter int STEPS  = 16,
   parameter int OPS    = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              halt,
   input logic [STEPS-1:0]  t_step,
   input logic [2:0]        bus_sel,
   input logic [DATA_W-1:0] bus_data,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] ar,
   input logic [DATA_W-1:0] ir,
   input logic [OPS-1:0]    op_dec,
   input logic [3:0]        instr_class
);

   a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
      $countones(t_step) == 1);

   a_r2_t3_wraps: assert property (@(posedge clk) disable iff (rst)
      (t_step[3] && !halt) |=> t_step[0]);

   a_r3_ar_gets_pc: assert property (@(posedge clk) disable iff (rst)
      (t_step[0] && !halt) |=> (ar == $past(pc)));

   a_r4_pc_steps: assert property (@(posedge clk) disable iff (rst)
      (t_step[1] && !halt) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

   a_r4_ir_gets_bus: assert property (@(posedge clk) disable iff (rst)
      (t_step[1] && !halt) |=> (ir == $past(bus_data)));

   a_r5_opdec_onehot: assert property (@(posedge clk) disable iff (rst)
      t_step[3] |-> ($countones(op_dec) == 1));

   a_r6_class_onehot: assert property (@(posedge clk) disable iff (rst)
      t_step[3] |-> ($countones(instr_class) == 1));

   a_r6_class_quiet: assert property (@(posedge clk) disable iff (rst)
      !t_step[3] |-> (instr_class == 4'b0000));

   a_r7_idle_bus: assert property (@(posedge clk) disable iff (rst)
      t_step[3] |-> (bus_sel == 3'b000 && bus_data == '0));

   a_r8_halt_freeze: assert property (@(posedge clk) disable iff (rst)
      halt |=> ($stable(t_step) && $stable(pc) && $stable(ar) && $stable(ir)));

endmodule

bind fetch_decode_core fdc_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .STEPS  (STEPS),
   .OPS    (OPS)
) u_fdc_checker (
   .clk         (clk),
   .rst         (rst),
   .halt        (halt),
   .t_step      (t_step),
   .bus_sel     (bus_sel),
   .bus_data    (bus_data),
   .pc          (pc),
   .ar          (ar),
   .ir          (ir),
   .op_dec      (op_dec),
   .instr_class (instr_class)
);

// File: tb/fetch_decode_core_tb_top.sv
`timescale 1ns/1ps
module fetch_decode_core_tb_top;

   localparam int AW = 12;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst;
   logic          halt;
   logic [AW-1:0] start_addr;
   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [DW-1:0] mem_wdata;
   logic [15:0]   t_step;
   logic [2:0]    bus_sel;
   logic [DW-1:0] bus_data;
   logic [AW-1:0] pc;
   logic [AW-1:0] ar;
   logic [DW-1:0] ir;
   logic          i_flag;
   logic [7:0]    op_dec;
   logic [3:0]    instr_class;

   int n_chk = 0;
   int n_bad = 0;
   logic [AW-1:0] pc_exp;

   always #10 clk = ~clk;

   fetch_decode_core dut_i (
      .clk(clk), .rst(rst), .halt(halt), .start_addr(start_addr),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .t_step(t_step), .bus_sel(bus_sel), .bus_data(bus_data),
      .pc(pc), .ar(ar), .ir(ir), .i_flag(i_flag), .op_dec(op_dec),
      .instr_class(instr_class)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
      mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
      step();
      mem_we = 1'b0;
   endtask

   task automatic t_reset_state();
      chk("R1 pc", 32'(pc), 32'(start_addr));
      chk("R1 t_step", 32'(t_step), 32'h1);
      chk("R1 class", 32'(instr_class), 32'h0);
      rst = 1'b0;
      step();
      step();
      chk("R8 t_step held", 32'(t_step), 32'h1);
      chk("R8 pc held", 32'(pc), 32'(start_addr));
      halt = 1'b0;
   endtask

   // entered at negedge inside T0
   task automatic t_run_instr(input logic [DW-1:0] word, input bit hold_t1,
                              input bit live_wr, input logic [DW-1:0] live_word);
      logic [DW-1:0] w;
      logic [DW-1:0] ir_before;
      logic [2:0]    opc;
      logic [3:0]    cls_exp;
      w   = live_wr ? live_word : word;
      opc = w[14:12];
      if (opc != 3'd7) cls_exp = w[15] ? 4'b0010 : 4'b0001;
      else             cls_exp = w[15] ? 4'b1000 : 4'b0100;

      chk("R2 T0", 32'(t_step), 32'h1);
      chk("R3 sel", 32'(bus_sel), 32'h2);
      chk("R3 bus", 32'(bus_data), 32'(pc_exp));
      chk("R6 quiet T0", 32'(instr_class), 32'h0);
      if (live_wr) begin
         mem_we = 1'b1; mem_waddr = pc_exp; mem_wdata = live_word;
      end
      step();
      mem_we = 1'b0;
      chk("R2 T1", 32'(t_step), 32'h2);
      chk("R3 ar", 32'(ar), 32'(pc_exp));
      chk("R4 sel", 32'(bus_sel), 32'h7);
      chk(live_wr ? "R9 live word" : "R4 bus", 32'(bus_data), 32'(w));
      if (hold_t1) begin
         ir_before = ir;
         halt = 1'b1;
         repeat (3) step();
         chk("R8 t_step", 32'(t_step), 32'h2);
         chk("R8 pc", 32'(pc), 32'(pc_exp));
         chk("R8 ar", 32'(ar), 32'(pc_exp));
         chk("R8 ir", 32'(ir), 32'(ir_before));
         halt = 1'b0;
      end
      step();
      chk("R2 T2", 32'(t_step), 32'h4);
      chk("R4 ir", 32'(ir), 32'(w));
      chk("R4 pc", 32'(pc), 32'(AW'(pc_exp + 1'b1)));
      chk("R5 sel", 32'(bus_sel), 32'h5);
      step();
      chk("R2 T3", 32'(t_step), 32'h8);
      chk("R5 ar", 32'(ar), 32'(w[11:0]));
      chk("R5 iflag", 32'(i_flag), 32'(w[15]));
      chk("R5 opdec", 32'(op_dec), 32'(8'h1 << opc));
      chk("R6 class", 32'(instr_class), 32'(cls_exp));
      chk("R7 sel", 32'(bus_sel), 32'h0);
      chk("R7 bus", 32'(bus_data), 32'h0);
      step();
      pc_exp = AW'(pc_exp + 1'b1);
      chk("R2 back to T0", 32'(t_step), 32'h1);
   endtask

   initial begin
      rst = 1'b1; halt = 1'b1; start_addr = 12'd4094;
      mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
      @(negedge clk);
      load_word(12'd4094, 16'h1234);
      load_word(12'd4095, 16'h9ABC);
      load_word(12'd0,    16'h7020);
      load_word(12'd1,    16'hF400);
      load_word(12'd2,    16'hE123);
      load_word(12'd3,    16'h0000);
      load_word(12'd4,    16'h0FFF);
      pc_exp = 12'd4094;
      t_reset_state();
      t_run_instr(16'h1234, 1'b0, 1'b0, 16'h0);  // R6 memory direct
      t_run_instr(16'h9ABC, 1'b1, 1'b0, 16'h0);  // R6 indirect, R8 hold, R4 wrap next
      t_run_instr(16'h7020, 1'b0, 1'b0, 16'h0);  // R6 register
      t_run_instr(16'hF400, 1'b0, 1'b0, 16'h0);  // R6 I/O
      t_run_instr(16'hE123, 1'b0, 1'b0, 16'h0);  // opcode 6 indirect
      t_run_instr(16'h0000, 1'b0, 1'b1, 16'h7800); // R9 live write
      t_run_instr(16'h0FFF, 1'b0, 1'b0, 16'h0);  // opcode 0 direct
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule